// File: doc/BRIEF.md
# Ping-Pong Trace Buffer Controller

This block holds two equal trace memory banks. At any moment one bank belongs to the producer, which streams trace bytes into it, and the other belongs to a debug host, which reads it or places its own data in it. When the producer's bank is full, or when a flush is requested on a panic, the controller swaps the two banks. It then exposes the filled length and a new sequence number through a shared control register, which the host polls.

There are two modes, selected by a host-connected bit in that register. With the host disconnected (post-mortem mode), a full bank is swapped at once and older trace data is overwritten. This keeps the latest trace for crash analysis. With the host connected (streaming mode), a swap waits until the host has released the previous bank by clearing the length field, and the producer is stalled in the meantime. The host can send data to the producer by writing it into its bank before the release and setting a host-data flag. After the next swap, the producer must read that data out before trace bytes are written over it.

A status register reads nonzero during the single cycle in which the controller reads and rewrites the control register. This lets a host that halts the system see that an update is in progress.

Top module: `ppt_buffer_ctrl`

## Requirements
- R1: After reset, the producer owns bank 0, the control register reads 0 (sequence 0, length 0, both flags clear), the status register reads 0, and `prod_full`, `hd_pending` and `flush_timeout` are 0.
- R2: The producer and the host always use different banks. Accepted producer bytes fill the producer bank from address 0 upward. Host memory reads and writes reach only the other bank, and read data appears one cycle after the address.
- R3: The control word has its length in bits 14..0, the sequence number in bits 21..15, host-data in bit 22 and host-connected in bit 23. Bits 31..24 read 0. A host write to bits 21..15 has no effect, and a host write with `host_reg_sel`=1 (status) has no effect.
- R4: With host-connected clear, a full producer bank is swapped two cycles after it fills, whatever the length field holds.
- R5: A swap sets the sequence field to its old value plus one modulo 128 (127 wraps to 0), the length to the number of bytes in the bank just filled, and host-data to 0. Host-connected is kept.
- R6: With host-connected set, a swap happens only while the length field is 0 and the sequence field matches the controller's own count. Until then, `prod_full` stays 1 and the bank select does not change.
- R7: If host-data was set when a swap commits, `hd_pending` rises. Producer writes are refused until a `hd_release` pulse, and the producer read port returns the host's bytes from the new producer bank.
- R8: The status register reads the nonzero code 0x000000A5 for exactly the one cycle in which the swap decision is made, and reads 0 at all other times.
- R9: A `flush_req` exposes the partly filled producer bank through a swap when its fill count is at least `flush_thresh`. Below the threshold, the request is dropped and the bank, the sequence and the producer stall are unchanged.
- R10: In streaming mode, a flush that gets no release within `flush_tmo` cycles is abandoned. `flush_timeout` is set until the next `flush_req`, the bank is not swapped and the producer is no longer stalled.
- R11: A host control write in the cycle in which a swap commits takes effect for the length and host-data bits, and the swap still advances the sequence and flips the banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_wr_en | input | 1 | Producer byte write request |
| prod_wr_data | input | DATA_W | Producer byte |
| prod_full | output | 1 | Producer write refused this cycle (stall) |
| prod_rd_addr | input | ADDR_W | Producer read address in its own bank |
| prod_rd_data | output | DATA_W | Producer read data, one cycle later |
| hd_pending | output | 1 | Producer bank holds host data not yet consumed |
| hd_release | input | 1 | Producer has consumed the host data |
| prod_bank_sel | output | 1 | Bank currently owned by the producer |
| host_reg_wr | input | 1 | Host register write strobe |
| host_reg_sel | input | 1 | 0 = control register, 1 = status register |
| host_reg_wdata | input | 32 | Host register write data |
| host_reg_rdata | output | 32 | Register selected by host_reg_sel |
| host_mem_wr | input | 1 | Host byte write into the host bank |
| host_mem_addr | input | ADDR_W | Host bank address |
| host_mem_wdata | input | DATA_W | Host byte |
| host_mem_rdata | output | DATA_W | Host bank read data, one cycle later |
| flush_req | input | 1 | Panic flush request pulse |
| flush_thresh | input | 15 | Minimum fill count for a flush to take place |
| flush_tmo | input | TMO_W | Streaming flush wait limit in cycles |
| flush_timeout | output | 1 | Last flush was abandoned for lack of release |

## Verification
The assertions assume that `flush_req` and `hd_release` are single-cycle pulses, that a flush is not requested in the cycle in which a full bank commits its swap, and that `BANK_BYTES` fits the 15-bit length field. The bench drives every input at the falling edge. It raises a flush only while the controller is idle and below full, and it pulses the release only while host data is pending. For the same-cycle write case it first reads the status code, which confirms the decision cycle before it issues the host write. This keeps every stimulus inside those assumptions.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    localparam int LEN_W  = 15;
    localparam int ID_W   = 7;
    localparam int CTRL_W = 24;
    localparam int REG_W  = 32;

    // Field order is the register layout, MSB first.
    typedef struct packed {
        logic              host_on;
        logic              host_data;
        logic [ID_W-1:0]   seq;
        logic [LEN_W-1:0]  len;
    } ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOCK = 1'b1
    } swap_st_t;

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        return {{(REG_W-CTRL_W){1'b0}}, c};
    endfunction

    function automatic ctrl_t bits_to_ctrl(input logic [CTRL_W-1:0] b);
        return ctrl_t'(b);
    endfunction

    function automatic logic [ID_W-1:0] next_seq(input logic [ID_W-1:0] s);
        return s + 1'b1;
    endfunction

endpackage

// File: rtl/ppt_bank_ram.sv
module ppt_bank_ram #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/ppt_bank_array.sv
module ppt_bank_array #(
    parameter int BANK_BYTES = 1024,
    parameter int DATA_W     = 8,
    localparam int ADDR_W    = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_bank,
    input  logic              prod_we,
    input  logic [ADDR_W-1:0] prod_wr_addr,
    input  logic [DATA_W-1:0] prod_wdata,
    input  logic [ADDR_W-1:0] prod_rd_addr,
    output logic [DATA_W-1:0] prod_rdata,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    localparam int NBANK = 2;

    logic [DATA_W-1:0] rd_w [NBANK];
    logic [ADDR_W-1:0] prod_addr;
    logic              sel_q;

    assign prod_addr = prod_we ? prod_wr_addr : prod_rd_addr;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic              own;
        logic              we_b;
        logic [ADDR_W-1:0] a_b;
        logic [DATA_W-1:0] d_b;

        assign own  = (prod_bank == 1'(b));
        assign we_b = own ? prod_we    : host_we;
        assign a_b  = own ? prod_addr  : host_addr;
        assign d_b  = own ? prod_wdata : host_wdata;

        ppt_bank_ram #(
            .DEPTH  (BANK_BYTES),
            .DATA_W (DATA_W)
        ) u_ram (
            .clk   (clk),
            .we    (we_b),
            .addr  (a_b),
            .wdata (d_b),
            .rdata (rd_w[b])
        );
    end

    // Read data lags the address by one cycle, so steer it with the
    // select that was in force when the address was sampled.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= prod_bank;
        end
    end

    assign prod_rdata = rd_w[sel_q];
    assign host_rdata = rd_w[sel_q ^ 1'b1];

endmodule

// File: rtl/ppt_swap_engine.sv
module ppt_swap_engine
    import ppt_pkg::*;
#(
    parameter int               BANK_BYTES = 1024,
    parameter int               TMO_W      = 16,
    parameter logic [REG_W-1:0] BUSY_CODE  = 32'h0000_00A5,
    localparam int              CNT_W      = $clog2(BANK_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_wr_en,
    output logic              prod_full,
    output logic              prod_we,
    output logic [CNT_W-1:0]  fill_cnt,
    output logic              prod_bank,
    input  logic              hd_release,
    output logic              hd_pending,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              flush_req,
    input  logic [LEN_W-1:0]  flush_thresh,
    input  logic [TMO_W-1:0]  flush_tmo,
    output logic              flush_timeout
);

    ctrl_t            ctrl_q;
    logic [ID_W-1:0]  seq_q;
    swap_st_t         st_q;
    logic [CNT_W-1:0] fill_q;
    logic             bank_q;
    logic             hdpend_q;
    logic             fpend_q;
    logic             fto_q;
    logic [TMO_W-1:0] tmo_q;
    logic [REG_W-1:0] stat_q;

    logic             bank_full;
    logic             need_swap;
    logic             host_acked;
    logic             swap_ok;
    logic             commit;
    logic             stall;
    logic             wr_take;
    logic             ctrl_wr;
    ctrl_t            wr_fields;
    logic [LEN_W-1:0] fill_len;
    logic             flush_ok;
    logic             tmo_hit;
    logic             unused_wbits;

    assign bank_full  = (fill_q == CNT_W'(BANK_BYTES));
    assign need_swap  = bank_full | fpend_q;
    assign host_acked = (ctrl_q.len == '0) && (ctrl_q.seq == seq_q);
    assign swap_ok    = !ctrl_q.host_on || host_acked;
    assign commit     = (st_q == ST_LOCK) && need_swap && swap_ok;
    assign stall      = bank_full | hdpend_q | fpend_q | (st_q == ST_LOCK);
    assign wr_take    = prod_wr_en && !stall;
    assign ctrl_wr    = reg_wr_en && (reg_sel == 1'b0);
    assign wr_fields  = bits_to_ctrl(reg_wdata[CTRL_W-1:0]);
    assign fill_len   = LEN_W'(fill_q);
    assign flush_ok   = flush_req && !fpend_q && (fill_len >= flush_thresh);
    assign tmo_hit    = fpend_q && ctrl_q.host_on && (tmo_q >= flush_tmo) && !commit;
    assign unused_wbits = ^{reg_wdata[REG_W-1:CTRL_W], wr_fields.seq};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            seq_q    <= '0;
            st_q     <= ST_IDLE;
            fill_q   <= '0;
            bank_q   <= 1'b0;
            hdpend_q <= 1'b0;
            fpend_q  <= 1'b0;
            fto_q    <= 1'b0;
            tmo_q    <= '0;
            stat_q   <= '0;
        end else begin
            // lock cycle: status is raised while the decision is made
            case (st_q)
                ST_IDLE: begin
                    if (need_swap) begin
                        st_q   <= ST_LOCK;
                        stat_q <= BUSY_CODE;
                    end
                end
                default: begin
                    st_q   <= ST_IDLE;
                    stat_q <= '0;
                end
            endcase

            // swap commit and fill pointer
            if (commit) begin
                bank_q           <= ~bank_q;
                fill_q           <= '0;
                seq_q            <= next_seq(seq_q);
                ctrl_q.seq       <= next_seq(ctrl_q.seq);
                ctrl_q.len       <= fill_len;
                ctrl_q.host_data <= 1'b0;
            end else if (wr_take) begin
                fill_q <= fill_q + 1'b1;
            end

            // host write: wins over the commit for length and host-data
            if (ctrl_wr) begin
                ctrl_q.len       <= wr_fields.len;
                ctrl_q.host_data <= wr_fields.host_data;
                ctrl_q.host_on   <= wr_fields.host_on;
            end

            if (commit) begin
                hdpend_q <= ctrl_q.host_data;
            end else if (hd_release) begin
                hdpend_q <= 1'b0;
            end

            // flush request, wait and timeout
            if (flush_req) begin
                fto_q <= 1'b0;
            end
            if (flush_ok) begin
                fpend_q <= 1'b1;
                tmo_q   <= '0;
            end else if (commit) begin
                fpend_q <= 1'b0;
            end else if (tmo_hit) begin
                fpend_q <= 1'b0;
                fto_q   <= 1'b1;
            end else if (fpend_q && ctrl_q.host_on) begin
                tmo_q <= tmo_q + 1'b1;
            end
        end
    end

    assign prod_full     = stall;
    assign prod_we       = wr_take;
    assign fill_cnt      = fill_q;
    assign prod_bank     = bank_q;
    assign hd_pending    = hdpend_q;
    assign flush_timeout = fto_q;
    assign reg_rdata     = reg_sel ? stat_q : ctrl_to_word(ctrl_q);

    // R2: fill count never passes the bank size
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_q <= CNT_W'(BANK_BYTES));

    // R4: disconnected host -> decision cycle always swaps
    a_r4_postmortem_swap: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCK && need_swap && !ctrl_q.host_on)
        |=> (fill_q == '0 && bank_q != $past(bank_q)));

    // R6: connected host with unreleased length -> no swap
    a_r6_stream_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCK && ctrl_q.host_on && ctrl_q.len != '0)
        |=> (bank_q == $past(bank_q)));

    // R5: every bank flip advances the sequence field by one, modulo 128
    a_r5_seq_step: assert property (@(posedge clk) disable iff (rst)
        (bank_q != $past(bank_q))
        |-> (ctrl_q.seq == ID_W'($past(ctrl_q.seq) + 1'b1)));

    // R8: busy status lasts a single cycle
    a_r8_status_pulse: assert property (@(posedge clk) disable iff (rst)
        (stat_q != '0) |=> (stat_q == '0));

    // R7: pending host data blocks producer writes
    a_r7_hold_writes: assert property (@(posedge clk) disable iff (rst)
        (hdpend_q && prod_wr_en)
        |=> (fill_q == $past(fill_q) || fill_q == '0));

    // R10: a timeout only arises with the host connected
    a_r10_timeout_streaming: assert property (@(posedge clk) disable iff (rst)
        $rose(fto_q) |-> $past(ctrl_q.host_on));

endmodule

// File: rtl/ppt_buffer_ctrl.sv
module ppt_buffer_ctrl
    import ppt_pkg::*;
#(
    parameter int               BANK_BYTES = 1024,
    parameter int               DATA_W     = 8,
    parameter int               TMO_W      = 16,
    parameter logic [REG_W-1:0] BUSY_CODE  = 32'h0000_00A5,
    localparam int              ADDR_W     = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_wr_en,
    input  logic [DATA_W-1:0] prod_wr_data,
    output logic              prod_full,
    input  logic [ADDR_W-1:0] prod_rd_addr,
    output logic [DATA_W-1:0] prod_rd_data,
    output logic              hd_pending,
    input  logic              hd_release,
    output logic              prod_bank_sel,
    input  logic              host_reg_wr,
    input  logic              host_reg_sel,
    input  logic [REG_W-1:0]  host_reg_wdata,
    output logic [REG_W-1:0]  host_reg_rdata,
    input  logic              host_mem_wr,
    input  logic [ADDR_W-1:0] host_mem_addr,
    input  logic [DATA_W-1:0] host_mem_wdata,
    output logic [DATA_W-1:0] host_mem_rdata,
    input  logic              flush_req,
    input  logic [LEN_W-1:0]  flush_thresh,
    input  logic [TMO_W-1:0]  flush_tmo,
    output logic              flush_timeout
);

    localparam int CNT_W = ADDR_W + 1;

    logic             bank;
    logic             we;
    logic [CNT_W-1:0] fill;

    ppt_swap_engine #(
        .BANK_BYTES (BANK_BYTES),
        .TMO_W      (TMO_W),
        .BUSY_CODE  (BUSY_CODE)
    ) u_engine (
        .clk           (clk),
        .rst           (rst),
        .prod_wr_en    (prod_wr_en),
        .prod_full     (prod_full),
        .prod_we       (we),
        .fill_cnt      (fill),
        .prod_bank     (bank),
        .hd_release    (hd_release),
        .hd_pending    (hd_pending),
        .reg_wr_en     (host_reg_wr),
        .reg_sel       (host_reg_sel),
        .reg_wdata     (host_reg_wdata),
        .reg_rdata     (host_reg_rdata),
        .flush_req     (flush_req),
        .flush_thresh  (flush_thresh),
        .flush_tmo     (flush_tmo),
        .flush_timeout (flush_timeout)
    );

    ppt_bank_array #(
        .BANK_BYTES (BANK_BYTES),
        .DATA_W     (DATA_W)
    ) u_banks (
        .clk          (clk),
        .rst          (rst),
        .prod_bank    (bank),
        .prod_we      (we),
        .prod_wr_addr (fill[ADDR_W-1:0]),
        .prod_wdata   (prod_wr_data),
        .prod_rd_addr (prod_rd_addr),
        .prod_rdata   (prod_rd_data),
        .host_we      (host_mem_wr),
        .host_addr    (host_mem_addr),
        .host_wdata   (host_mem_wdata),
        .host_rdata   (host_mem_rdata)
    );

    assign prod_bank_sel = bank;

endmodule

// File: tb/sim_ppt_buffer_ctrl.sv
module sim_ppt_buffer_ctrl;

    localparam int          BB   = 16;
    localparam int          AW   = 4;
    localparam int          TW   = 8;
    localparam logic [31:0] BUSY = 32'h0000_00A5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prod_wr_en = 1'b0;
    logic [7:0]    prod_wr_data = '0;
    logic          prod_full;
    logic [AW-1:0] prod_rd_addr = '0;
    logic [7:0]    prod_rd_data;
    logic          hd_pending;
    logic          hd_release = 1'b0;
    logic          prod_bank_sel;
    logic          host_reg_wr = 1'b0;
    logic          host_reg_sel = 1'b0;
    logic [31:0]   host_reg_wdata = '0;
    logic [31:0]   host_reg_rdata;
    logic          host_mem_wr = 1'b0;
    logic [AW-1:0] host_mem_addr = '0;
    logic [7:0]    host_mem_wdata = '0;
    logic [7:0]    host_mem_rdata;
    logic          flush_req = 1'b0;
    logic [14:0]   flush_thresh = '0;
    logic [TW-1:0] flush_tmo = 8'd20;
    logic          flush_timeout;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ppt_buffer_ctrl #(.BANK_BYTES(BB), .TMO_W(TW)) u0 (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit hc, input bit hdp, input int id, input int len);
        return {8'h00, hc, hdp, 7'(id), 15'(len)};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] v);
        host_reg_sel = sel;
        #1;
        v = host_reg_rdata;
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] v);
        host_reg_sel   = sel;
        host_reg_wdata = v;
        host_reg_wr    = 1'b1;
        @(negedge clk);
        host_reg_wr    = 1'b0;
        host_reg_sel   = 1'b0;
    endtask

    task automatic push(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            while (prod_full) @(negedge clk);
            prod_wr_en   = 1'b1;
            prod_wr_data = base + 8'(i);
            @(negedge clk);
            prod_wr_en   = 1'b0;
        end
    endtask

    task automatic host_rd(input int a, output logic [7:0] v);
        host_mem_addr = AW'(a);
        @(negedge clk);
        v = host_mem_rdata;
    endtask

    task automatic prod_rd(input int a, output logic [7:0] v);
        prod_rd_addr = AW'(a);
        @(negedge clk);
        v = prod_rd_data;
    endtask

    task automatic flush_once(input int thr);
        flush_thresh = 15'(thr);
        flush_req    = 1'b1;
        @(negedge clk);
        flush_req    = 1'b0;
        idle(3);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_reg(1'b0, v); check(v, 32'h0, "R1 ctrl after reset");
        rd_reg(1'b1, v); check(v, 32'h0, "R1 status after reset");
        check({31'h0, prod_full}, 32'h0, "R1 prod_full after reset");
        check({31'h0, prod_bank_sel}, 32'h0, "R1 bank after reset");
        check({31'h0, hd_pending}, 32'h0, "R1 hd_pending after reset");
        check({31'h0, flush_timeout}, 32'h0, "R1 flush_timeout after reset");
    endtask

    task automatic t_postmortem;
        logic [31:0] v;
        logic [7:0]  b;
        bit          saw_busy;
        push(BB, 8'h10);
        saw_busy = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rd_reg(1'b1, v);
            if (v == BUSY) saw_busy = 1'b1;
            @(negedge clk);
        end
        check({31'h0, saw_busy}, 32'h1, "R8 busy code seen during swap");
        rd_reg(1'b1, v); check(v, 32'h0, "R8 status back to zero");
        rd_reg(1'b0, v); check(v, cw(0, 0, 1, 16), "R4 R5 ctrl after first swap");
        check({31'h0, prod_bank_sel}, 32'h1, "R4 bank flipped");
        host_rd(0, b);  check({24'h0, b}, 32'h10, "R2 host reads byte 0");
        host_rd(15, b); check({24'h0, b}, 32'h1F, "R2 host reads byte 15");
        push(BB, 8'h30);
        idle(4);
        rd_reg(1'b0, v); check(v, cw(0, 0, 2, 16), "R4 swap without release");
        check({31'h0, prod_bank_sel}, 32'h0, "R4 bank back to 0");
        host_rd(5, b);  check({24'h0, b}, 32'h35, "R2 host reads other bank");
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_reg(1'b0, v); check(v, cw(1, 1, 2, 15'h7FFF), "R3 seq ignored, top byte zero");
        wr_reg(1'b1, 32'h0000_1234);
        rd_reg(1'b1, v); check(v, 32'h0, "R3 status write ignored");
        wr_reg(1'b0, 32'h0);
        rd_reg(1'b0, v); check(v, cw(0, 0, 2, 0), "R3 ctrl cleared");
    endtask

    task automatic t_stream;
        logic [31:0] v;
        logic [7:0]  b;
        wr_reg(1'b0, cw(1, 0, 0, 7));
        push(BB, 8'h40);
        idle(20);
        check({31'h0, prod_full}, 32'h1, "R6 producer stalled");
        check({31'h0, prod_bank_sel}, 32'h0, "R6 no swap without release");
        rd_reg(1'b0, v); check(v, cw(1, 0, 2, 7), "R6 ctrl unchanged");
        host_mem_addr = 4'd3; host_mem_wdata = 8'h5A; host_mem_wr = 1'b1;
        @(negedge clk);
        host_mem_wr = 1'b0;
        wr_reg(1'b0, cw(1, 1, 0, 0));
        idle(4);
        check({31'h0, prod_bank_sel}, 32'h1, "R6 swap after release");
        rd_reg(1'b0, v); check(v, cw(1, 0, 3, 16), "R5 ctrl after streaming swap");
        check({31'h0, hd_pending}, 32'h1, "R7 host data pending");
        check({31'h0, prod_full}, 32'h1, "R7 writes refused while pending");
        prod_wr_en = 1'b1; prod_wr_data = 8'hEE;
        @(negedge clk);
        prod_wr_en = 1'b0;
        prod_rd(0, b); check({24'h0, b}, 32'h30, "R7 refused write left byte 0");
        prod_rd(3, b); check({24'h0, b}, 32'h5A, "R7 host byte readable");
        hd_release = 1'b1;
        @(negedge clk);
        hd_release = 1'b0;
        check({31'h0, hd_pending}, 32'h0, "R7 pending cleared");
        check({31'h0, prod_full}, 32'h0, "R7 producer resumes");
        host_rd(2, b); check({24'h0, b}, 32'h42, "R2 host reads streamed bank");
        wr_reg(1'b0, 32'h0);
    endtask

    task automatic t_flush;
        logic [31:0] v;
        push(3, 8'h60);
        flush_once(4);
        check({31'h0, prod_bank_sel}, 32'h1, "R9 flush below threshold dropped");
        rd_reg(1'b0, v); check(v, cw(0, 0, 3, 0), "R9 ctrl unchanged on drop");
        check({31'h0, prod_full}, 32'h0, "R9 no stall on drop");
        flush_once(3);
        check({31'h0, prod_bank_sel}, 32'h0, "R9 flush swaps");
        rd_reg(1'b0, v); check(v, cw(0, 0, 4, 3), "R9 partial length exposed");
    endtask

    task automatic t_flush_tmo;
        wr_reg(1'b0, cw(1, 0, 0, 9));
        push(2, 8'h70);
        flush_thresh = 15'd1;
        flush_req    = 1'b1;
        @(negedge clk);
        flush_req    = 1'b0;
        idle(10);
        check({31'h0, flush_timeout}, 32'h0, "R10 no timeout before limit");
        idle(30);
        check({31'h0, flush_timeout}, 32'h1, "R10 timeout flagged");
        check({31'h0, prod_bank_sel}, 32'h0, "R10 no swap on timeout");
        check({31'h0, prod_full}, 32'h0, "R10 producer released");
        wr_reg(1'b0, 32'h0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        flush_thresh = 15'd0;
        flush_req    = 1'b1;
        @(negedge clk);
        flush_req    = 1'b0;
        @(negedge clk);
        rd_reg(1'b1, v); check(v, BUSY, "R8 decision cycle shows busy");
        wr_reg(1'b0, cw(0, 1, 0, 15'h0AB));
        rd_reg(1'b0, v); check(v, cw(0, 1, 5, 15'h0AB), "R11 host write wins on len and flag");
        check({31'h0, prod_bank_sel}, 32'h1, "R11 banks still flipped");
        wr_reg(1'b0, 32'h0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        for (int i = 0; i < 122; i++) flush_once(0);
        rd_reg(1'b0, v); check((v >> 15) & 32'h7F, 32'd127, "R5 sequence reaches 127");
        flush_once(0);
        rd_reg(1'b0, v); check((v >> 15) & 32'h7F, 32'd0, "R5 sequence wraps to 0");
        check({31'h0, prod_bank_sel}, 32'h0, "R5 bank after wrap");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_postmortem();
        t_regs();
        t_stream();
        t_flush();
        t_flush_tmo();
        t_same_cycle();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R1..: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule